// File: doc/BRIEF.md
# Complementary Dead-Band Generator

This block turns one PWM drive signal into a complementary pair of gate signals for a half-bridge. Each output has its own dead time. Output A copies the input, but each rising edge is held back by a programmed number of delay ticks and each falling edge passes at once. Output B is the complement: its rising edge is held back after the input falls, and it drops as soon as the input rises. As a result, both switches are off for a programmed interval around every transition. Each path has a bypass (enable low) and an output inversion bit. A rate select sets how often the delay counters advance: every clock or every second clock.

Both paths use the same delay-unit state machine. The A path feeds it the input, and the B path feeds it the inverted input. The machine has three states: IDLE (output off), WAIT (dead time running) and ON (output on). Its transitions are:
- *start*: IDLE to WAIT, when the source goes high with a non-zero count.
- *immediate*: IDLE to ON, when the count is zero.
- *expire*: WAIT to ON, when the last tick is consumed.
- *cancel*: WAIT to IDLE, when the source drops early.
- *release*: ON to IDLE, when the source drops.
- *bypass*: any state to ON or IDLE, copying the source, while the path is disabled.

Every output change follows the input by at least one register stage.

Top module: `deadband_pair`

## Requirements
- R1: While reset is asserted, out_a equals rise_inv and out_b equals the inverse of fall_inv.
- R2: With rise_en=1 and half_rate=0, out_a (rise_inv=0) goes high at the clock edge rise_dly cycles after the first edge that samples pwm_in high.
- R3: out_a returns to its inactive level (equal to rise_inv) right after the first edge that samples pwm_in low.
- R4: With fall_en=1, fall_inv=1 and half_rate=0, out_b goes high fall_dly cycles after the first edge that samples pwm_in low. It goes low right after the first edge that samples pwm_in high.
- R5: If pwm_in holds a level for no more cycles than the effective delay, the delayed edge is cancelled and that output stays inactive for that pulse.
- R6: A delay count of zero adds no dead time. The output changes at the same edge that samples the input change.
- R7: With a path's enable low, its output equals the previous-cycle pwm_in XOR that path's invert bit (rise_inv for out_a, fall_inv for out_b).
- R8: Setting an invert bit inverts that output's level in every case.
- R9: With half_rate=1, the effective delay is twice the programmed count.
- R10: A delay value is captured when a dead-time interval starts. Changing rise_dly or fall_dly during the interval does not change its length.
- R11: With rise_inv=0 and fall_inv=1, out_a and out_b are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM source for both paths |
| rise_dly | input | 10 | Dead-time ticks before out_a turns on |
| fall_dly | input | 10 | Dead-time ticks before out_b turns on |
| rise_en | input | 1 | 1 = delay the A path, 0 = bypass |
| fall_en | input | 1 | 1 = delay the B path, 0 = bypass |
| rise_inv | input | 1 | Invert out_a |
| fall_inv | input | 1 | Invert out_b relative to pwm_in (1 = complementary) |
| half_rate | input | 1 | 1 = counters advance every second clock |
| out_a | output | 1 | Delayed true output |
| out_b | output | 1 | Delayed complementary output |

## Verification
A delay unit stuck in WAIT or ON shows at the ports within one clock after the input next changes. The output either fails to drop right after that edge or turns on while the other output is still high, so the overlap and immediate-release properties catch it. A wrong tick count or a wrongly captured delay value shifts the turn-on edge by whole cycles. Measuring the first active cycle and the count of active cycles in every pulse window exposes that by the end of the same pulse.

// File: rtl/deadband_pkg.sv
package deadband_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ON   = 2'd2
    } db_state_e;

    localparam int DB_CNT_W   = 10;
    localparam int DB_N_PATHS = 2;
endpackage

// File: rtl/deadband_delay_unit.sv
module deadband_delay_unit
    import deadband_pkg::*;
#(
    parameter int CW = DB_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src,
    input  logic          en,
    input  logic          half,
    input  logic [CW-1:0] dly,
    output logic          act
);
    db_state_e     st, st_n;
    logic [CW-1:0] rem, rem_n;
    logic          ph, ph_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            rem <= '0;
            ph  <= 1'b0;
        end else begin
            st  <= st_n;
            rem <= rem_n;
            ph  <= ph_n;
        end
    end

    // transitions
    always_comb begin
        st_n  = st;
        rem_n = rem;
        ph_n  = ph;
        if (!en) begin
            st_n  = src ? ST_ON : ST_IDLE;   // bypass
            rem_n = '0;
            ph_n  = 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (src) begin
                        if (dly == '0) begin
                            st_n = ST_ON;     // immediate
                        end else begin
                            st_n  = ST_WAIT;  // start: capture delay
                            rem_n = dly;
                            ph_n  = 1'b0;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!src) begin
                        st_n = ST_IDLE;       // cancel
                    end else begin
                        ph_n = ~ph;
                        if (!half || ph) begin
                            if (rem == CW'(1)) st_n = ST_ON;   // expire
                            else               rem_n = rem - 1'b1;
                        end
                    end
                end
                ST_ON: begin
                    if (!src) st_n = ST_IDLE; // release
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        act = (st == ST_ON);
    end
endmodule

// File: rtl/deadband_polarity.sv
module deadband_polarity (
    input  logic raw,
    input  logic inv,
    output logic o
);
    always_comb begin
        o = raw ^ inv;
    end
endmodule

// File: rtl/deadband_pair.sv
module deadband_pair
    import deadband_pkg::*;
#(
    parameter int CW = DB_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_in,
    input  logic [CW-1:0] rise_dly,
    input  logic [CW-1:0] fall_dly,
    input  logic          rise_en,
    input  logic          fall_en,
    input  logic          rise_inv,
    input  logic          fall_inv,
    input  logic          half_rate,
    output logic          out_a,
    output logic          out_b
);
    localparam int NP = DB_N_PATHS;

    logic          src  [NP];
    logic          en   [NP];
    logic          inv  [NP];
    logic [CW-1:0] dly  [NP];
    logic          act  [NP];
    logic          raw  [NP];
    logic          pol  [NP];

    always_comb begin
        src[0] = pwm_in;
        src[1] = ~pwm_in;
        en[0]  = rise_en;
        en[1]  = fall_en;
        dly[0] = rise_dly;
        dly[1] = fall_dly;
        inv[0] = rise_inv;
        inv[1] = fall_inv;
        raw[0] = act[0];
        raw[1] = ~act[1];   // B path: falling-edge delayed copy of the input
        out_a  = pol[0];
        out_b  = pol[1];
    end

    for (genvar p = 0; p < NP; p++) begin : g_path
        deadband_delay_unit #(.CW(CW)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (src[p]),
            .en    (en[p]),
            .half  (half_rate),
            .dly   (dly[p]),
            .act   (act[p])
        );
        deadband_polarity u_pol (
            .raw (raw[p]),
            .inv (inv[p]),
            .o   (pol[p])
        );
    end
endmodule

// File: rtl/deadband_pair_chk.sv
module deadband_pair_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_in,
    input logic rise_en,
    input logic fall_en,
    input logic rise_inv,
    input logic fall_inv,
    input logic out_a,
    input logic out_b
);
    a_r3_a_drops_at_once: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_in |=> (out_a == rise_inv));

    a_r4_b_drops_at_once: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_in |=> (out_b == !fall_inv));

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_inv && fall_inv) |-> !(out_a && out_b));

    a_r7_a_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_en |=> (out_a == ($past(pwm_in) ^ rise_inv)));

    a_r7_b_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_en |=> (out_b == ($past(pwm_in) ^ fall_inv)));

    a_r2_rise_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_a) && !rise_inv && $stable(rise_inv)) |-> $past(pwm_in));
endmodule

bind deadband_pair deadband_pair_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_in   (pwm_in),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .rise_inv (rise_inv),
    .fall_inv (fall_inv),
    .out_a    (out_a),
    .out_b    (out_b)
);

// File: tb/deadband_pair_tb_top.sv
module deadband_pair_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic [9:0] rise_dly = '0;
    logic [9:0] fall_dly = '0;
    logic       rise_en = 1'b1;
    logic       fall_en = 1'b1;
    logic       rise_inv = 1'b0;
    logic       fall_inv = 1'b1;
    logic       half_rate = 1'b0;
    logic       out_a, out_b;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    deadband_pair dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
        .rise_dly(rise_dly), .fall_dly(fall_dly),
        .rise_en(rise_en), .fall_en(fall_en),
        .rise_inv(rise_inv), .fall_inv(fall_inv),
        .half_rate(half_rate), .out_a(out_a), .out_b(out_b)
    );

    // columns: rise, fall, half, high_len, low_len, rinv, finv
    localparam int NV = 7;
    localparam int VEC [NV][7] = '{
        '{3,  2, 0,  8, 6, 0, 1},   // R2 R4 basic
        '{0,  0, 0,  4, 4, 0, 1},   // R6 zero dead time
        '{5,  4, 0,  4, 3, 0, 1},   // R5 both edges cancelled
        '{3,  2, 1, 10, 8, 0, 1},   // R9 half rate
        '{1,  7, 0,  2, 9, 1, 0},   // R8 both outputs inverted
        '{10, 1, 1, 30, 5, 0, 1},   // R9 long half-rate delay
        '{2,  3, 0,  3, 3, 0, 1}    // R5 one cycle short of cancel
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_pulse(input int rd, input int fd, input int hf, input int hl,
                             input int ll, input int ri, input int fi, input int mid,
                             output int a_on, output int a_first, output int b_on,
                             output int ovl);
        @(negedge clk);
        pwm_in    = 1'b0;
        rise_dly  = 10'(rd);
        fall_dly  = 10'(fd);
        half_rate = hf[0];
        rise_inv  = ri[0];
        fall_inv  = fi[0];
        for (int s = 0; s < 30; s++) @(negedge clk);
        a_on = 0; a_first = 0; b_on = 0; ovl = 0;
        pwm_in = 1'b1;                               // N0
        for (int t = 1; t <= hl + ll; t++) begin
            logic aa, bb;
            @(negedge clk);
            aa = out_a ^ rise_inv;
            bb = out_b ~^ fall_inv;
            if (aa) begin
                a_on++;
                if (a_first == 0) a_first = t;
            end
            if (t > hl && bb) b_on++;
            if (aa && bb) ovl++;
            if (t == 2 && mid >= 0) rise_dly = 10'(mid);
            pwm_in = (t < hl) ? 1'b1 : 1'b0;
        end
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int a_on, a_first, b_on, ovl, d, f, ea, eb, bad_a, bad_b;
        logic prev;
        logic pat [8] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

        // R1 reset state under two polarity settings
        repeat (3) @(negedge clk);
        chk(out_a == 1'b0, "R1 out_a in reset", int'(out_a), 0);
        chk(out_b == 1'b0, "R1 out_b in reset", int'(out_b), 0);
        rise_inv = 1'b1; fall_inv = 1'b0;
        @(negedge clk);
        chk(out_a == 1'b1, "R1 out_a in reset inverted", int'(out_a), 1);
        chk(out_b == 1'b1, "R1 out_b in reset inverted", int'(out_b), 1);
        rise_inv = 1'b0; fall_inv = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v < NV; v++) begin
            run_pulse(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
                      VEC[v][5], VEC[v][6], -1, a_on, a_first, b_on, ovl);
            d  = VEC[v][2] != 0 ? 2 * VEC[v][0] : VEC[v][0];
            f  = VEC[v][2] != 0 ? 2 * VEC[v][1] : VEC[v][1];
            ea = VEC[v][3] > d ? VEC[v][3] - d : 0;
            eb = VEC[v][4] > f ? VEC[v][4] - f : 0;
            chk(a_on == ea, "R2/R3/R5/R8/R9 out_a active cycles", a_on, ea);
            if (ea > 0)
                chk(a_first == d + 1, "R2/R6/R9 out_a turn-on cycle", a_first, d + 1);
            chk(b_on == eb, "R4/R5/R8/R9 out_b active cycles", b_on, eb);
            chk(ovl == 0, "R11 overlap cycles", ovl, 0);
        end

        // R10: delay changed during the interval does not change it
        run_pulse(6, 2, 0, 12, 4, 0, 1, 1, a_on, a_first, b_on, ovl);
        chk(a_first == 7, "R10 turn-on cycle after mid-interval change", a_first, 7);
        chk(a_on == 6, "R10 active cycles after mid-interval change", a_on, 6);

        // R7: bypass with no inversion, output is previous input
        @(negedge clk);
        rise_en = 1'b0; fall_en = 1'b0; rise_inv = 1'b0; fall_inv = 1'b0;
        rise_dly = 10'd5; fall_dly = 10'd5;
        bad_a = 0; bad_b = 0;
        prev = pwm_in;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            pwm_in = pat[i];
            prev = pat[i];
            @(negedge clk);
            if (out_a != prev) bad_a++;
            if (out_b != prev) bad_b++;
        end
        chk(bad_a == 0, "R7 out_a bypass mismatches", bad_a, 0);
        chk(bad_b == 0, "R7 out_b bypass mismatches", bad_b, 0);

        // R7 with R8: bypass with inversion
        rise_inv = 1'b1; fall_inv = 1'b1;
        bad_a = 0; bad_b = 0;
        for (int i = 0; i < 8; i++) begin
            pwm_in = ~pat[i];
            prev = ~pat[i];
            @(negedge clk);
            if (out_a != ~prev) bad_a++;
            if (out_b != ~prev) bad_b++;
        end
        chk(bad_a == 0, "R7 R8 out_a inverted bypass mismatches", bad_a, 0);
        chk(bad_b == 0, "R7 R8 out_b inverted bypass mismatches", bad_b, 0);

        rise_en = 1'b1; fall_en = 1'b1;
        run_pulse(2, 2, 0, 6, 6, 0, 1, -1, a_on, a_first, b_on, ovl);
        chk(a_on == 4, "R2 out_a after re-enable", a_on, 4);
        chk(b_on == 4, "R4 out_b after re-enable", b_on, 4);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule